// File: doc/BRIEF.md
# System Tick Timer

This block is a free-running tick counter with a programmable terminal value. A fixed prescaler divides the core clock by four, so a 100 MHz core clock gives 25 MHz ticks. Each tick advances a count register. When the next count would equal the programmed limit, the count returns to zero. At that moment a reached-limit flag and a pending interrupt are both raised. Software can read the running count at any time, which lets it interpolate time between interrupts. A limit of 250000 gives a 100 Hz interrupt at the nominal clock.

Software uses a small register port with three registers: the limit, the count with the flag in its top bit, and a 4-bit level select. The level select chooses which of sixteen interrupt lines the pending tick drives. Reading the limit register with the read strobe acknowledges the interrupt. Writing the limit restarts the count from zero.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the limit, count, flag and level select are all zero, and every interrupt line is low.
- R2: While the limit is nonzero, the count advances by one every 4 clock cycles. The first increment comes 4 cycles after the limit write. Address 1 reads the flag in bit 31 and the count in bits 30:0.
- R3: When the incremented count would equal the limit, the count reloads to 0 and the flag and pending interrupt are set. They are first set 4×limit cycles after the limit write, and again every 4×limit cycles after that.
- R4: A limit of zero holds the count at 0 and never sets the flag.
- R5: Writing address 0 loads the limit and clears the count, the prescaler phase, the flag and the pending interrupt, even if one is pending.
- R6: A read of address 0 with the read strobe clears the flag and the pending interrupt. If a wrap happens on the same edge, the wrap wins and the flag stays set.
- R7: Address 2 bits 3:0 hold the level select. Interrupt line N is high exactly when the flag is set and the level select is N. Level 0 drives no line.
- R8: Address 0 reads back the full 32-bit limit. Address 2 reads the level with bits 31:4 zero. Address 3 reads zero. Writes to addresses 1 and 3 change nothing.
- R9: Writing the level select does not disturb the count, the prescaler phase or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 limit, 1 count, 2 level |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rd | input | 1 | Read strobe; only has an effect at address 0 (acknowledge) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| irq_line | output | 16 | Interrupt lines, at most one high |

## Verification
Some properties are checked on every cycle by the assertions:
- the count stays below a nonzero limit;
- the count moves by at most one step per cycle or returns to zero;
- a zero limit keeps the count and flag clear;
- a limit write clears the state;
- a strobed limit read without a coinciding wrap clears the flag;
- at most one interrupt line is high.

Other behaviour only the bench scenarios can show:
- the exact cycle of each increment and wrap relative to the limit write;
- the wrap-beats-acknowledge tie;
- that writes to the level and to read-only addresses leave the count untouched;
- how the interrupt line follows later level changes.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 4,
  parameter int LVL_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 reg_addr,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic [(1<<LVL_W)-1:0]      irq_line
);
  localparam int CNT_W  = DATA_W - 1;
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int NLINES = 1 << LVL_W;
  localparam logic [1:0] A_LIMIT = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_LEVEL = 2'd2;

  logic [DATA_W-1:0] limit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              hit_q;

  logic              wr_lim, wr_lvl, rd_lim, run, tick, wrap;
  logic [DATA_W-1:0] cnt_nxt;

  assign wr_lim  = reg_wr && (reg_addr == A_LIMIT);
  assign wr_lvl  = reg_wr && (reg_addr == A_LEVEL);
  assign rd_lim  = reg_rd && (reg_addr == A_LIMIT);
  assign run     = (limit_q != '0);
  assign tick    = run && (pre_q == PRE_W'(PRESCALE - 1));
  assign cnt_nxt = {1'b0, cnt_q} + DATA_W'(1);
  assign wrap    = tick && (cnt_nxt == limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
      hit_q   <= 1'b0;
    end else if (wr_lim) begin
      limit_q <= reg_wdata;
      cnt_q   <= '0;
      pre_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (run)
        pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick)
        cnt_q <= wrap ? '0 : cnt_nxt[CNT_W-1:0];
      if (wrap)
        hit_q <= 1'b1;
      else if (rd_lim)
        hit_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl_q <= '0;
    else if (wr_lvl)
      lvl_q <= reg_wdata[LVL_W-1:0];
  end

  always_comb begin
    case (reg_addr)
      A_LIMIT: reg_rdata = limit_q;
      A_COUNT: reg_rdata = {hit_q, cnt_q};
      A_LEVEL: reg_rdata = {{(DATA_W-LVL_W){1'b0}}, lvl_q};
      default: reg_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i == 0) begin : g_none
      assign irq_line[i] = 1'b0;
    end else begin : g_drv
      assign irq_line[i] = hit_q && (lvl_q == LVL_W'(i));
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} < limit_q)); // R3
  AST_FLAG_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(tick)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_lim) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)); // R2
  AST_ZERO_LIMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt_q == '0) && !hit_q); // R4
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (cnt_q == '0) && !hit_q && (limit_q == $past(reg_wdata))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !wrap && !wr_lim) |=> !hit_q); // R6
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_line)); // R7
  AST_LEVEL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lvl && !tick) |=> (cnt_q == $past(cnt_q))); // R9
endmodule

// File: tb/test_sys_tick_timer.sv
`timescale 1ns/1ps
module test_sys_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_line;

  int nchk = 0, nerr = 0;
  int edges = 0, mark = 0, clr = 0;
  int cur_l = 0, cur_lvl = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edges++;

  sys_tick_timer i_sys_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line)
  );

  function automatic logic [31:0] exp_counter(int n, int l, int c);
    int cnt, lw;
    logic hit;
    if (l == 0) return 32'd0;
    cnt = (n / 4) % l;
    lw  = (n / (4 * l)) * (4 * l);
    hit = (lw >= 4 * l) && (lw >= c);
    return {hit, cnt[30:0]};
  endfunction

  function automatic logic [15:0] exp_irq(logic hit, int lvl);
    if (lvl == 0 || !hit) return 16'd0;
    return 16'd1 << lvl;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 2'd0) begin mark = edges; clr = 0; cur_l = int'(d); end
    if (a == 2'd2) cur_lvl = int'(d[3:0]);
  endtask

  task automatic ack(input string req);
    @(negedge clk);
    reg_addr = 2'd0; reg_rd = 1'b1; #1;
    check({req, " limit readback"}, reg_rdata, cur_l);
    @(posedge clk); #1;
    reg_rd = 1'b0;
    clr = edges - mark;
  endtask

  task automatic chk_state(input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = 2'd1; #1;
    e = exp_counter(edges - mark, cur_l, clr);
    check({req, " count"}, reg_rdata, e);
    check({req, " irq"}, {16'd0, irq_line}, {16'd0, exp_irq(e[31], cur_lvl)});
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wait_rel(input int t);
    while (edges - mark < t) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); reg_addr = 2'(a); #1;
      check("R1 register", reg_rdata, 32'd0);
    end
    check("R1 irq", {16'd0, irq_line}, 32'd0);

    // R4 zero limit stays idle
    wait_n(50);
    chk_state("R4 idle after reset");
    wr(2'd2, 32'd4);
    wr(2'd0, 32'd3);
    wait_n(40);
    chk_state("R3 short limit");
    wr(2'd0, 32'd0);
    wait_n(30);
    chk_state("R4 zero limit written");

    // R2 step by step, R3 first wrap
    wr(2'd2, 32'd3);
    wr(2'd0, 32'd5);
    for (int k = 0; k < 25; k++) chk_state("R2 stepping");
    wait_rel(20);
    chk_state("R3 first wrap");
    wait_rel(45);
    chk_state("R3 later period");

    // R6 acknowledge
    ack("R8");
    chk_state("R6 ack clears");
    wait_rel(82);
    chk_state("R6 re-raised");

    // R6 tie: wrap on same edge as ack, then ack alone
    wr(2'd0, 32'd1);
    wait_rel(7);
    ack("R8");
    chk_state("R6 wrap wins tie");
    wait_rel(9);
    ack("R8");
    chk_state("R6 ack between wraps");

    // R9 / R7 level changes mid-run
    wr(2'd0, 32'd6);
    wait_rel(30);
    wr(2'd2, 32'd9);
    chk_state("R9 level write keeps count");
    wait_rel(26);
    chk_state("R7 line follows level 9");
    wr(2'd2, 32'd0);
    chk_state("R7 level zero drives none");
    wr(2'd2, 32'hFFFF_FFF5);
    @(negedge clk); reg_addr = 2'd2; #1;
    check("R8 level readback", reg_rdata, 32'd5);
    chk_state("R7 line follows level 5");

    // R8 ignored writes
    wr(2'd1, 32'hFFFF_FFFF);
    chk_state("R8 count write ignored");
    wr(2'd3, 32'hA5A5_A5A5);
    @(negedge clk); reg_addr = 2'd3; #1;
    check("R8 unused address", reg_rdata, 32'd0);
    @(negedge clk); reg_addr = 2'd0; #1;
    check("R8 limit kept", reg_rdata, 32'd6);

    // R5 write while pending
    chk_state("R5 before rewrite");
    wr(2'd0, 32'd7);
    chk_state("R5 rewrite clears");

    // R2 nominal 100 Hz limit
    wr(2'd0, 32'd250000);
    wait_rel(1000);
    chk_state("R2 nominal limit");
    check("R2 nominal count", exp_counter(1000, 250000, 0), 32'd250);

    // random runs
    for (int it = 0; it < 40; it++) begin
      wr(2'd2, $urandom % 16);
      wr(2'd0, 1 + ($urandom % 24));
      wait_n($urandom % 300);
      chk_state("R3 random");
      if ($urandom % 2 == 1) begin
        ack("R8");
        wait_n($urandom % 40);
        chk_state("R6 random ack");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule